// File: doc/BRIEF.md
# Chainable Parallel-Load Right-Shift Register

This block holds a word of configurable width (five bits by default). On a rising clock edge it either captures a parallel input word, shifts its contents one place toward bit 0, or keeps its value. During a shift, a serial input bit enters at the most significant position. An active-low reset clears the word at any time, without waiting for a clock edge.

The least significant bit is also brought out as a serial output. This output is a plain wire from the bit-0 flop, with no register of its own. As a result, the serial output of one instance can drive the serial input of another. Two or more instances joined this way shift together as one longer register, with no cycle lost at the joins. The instance that receives the external serial input holds the upper bits.

Top module: `shreg_chainable`

## Requirements
- R1: While `rst_n` is low, every bit of `par_out` is 0 and `ser_out` is 0. This takes effect as soon as `rst_n` falls, without a clock edge.
- R2: When `load_en` is high at a rising clock edge, the register takes `par_in`, whatever the value of `shift_en`.
- R3: When `load_en` is low and `shift_en` is high at a rising clock edge, bit i takes the old bit i+1 and the top bit takes `ser_in`.
- R4: When both `load_en` and `shift_en` are low at a rising clock edge, the register keeps its value.
- R5: `ser_out` always equals bit 0 of the register. It changes in the same cycle as `par_out[0]`, not one cycle later.
- R6: `par_out` shows the register contents directly, updated by the same edge that changes the register.
- R7: When one instance's `ser_out` drives a second instance's `ser_in`, and both share clock, reset and enables, the pair behaves as one register of twice the width. The upper bits are held by the instance that receives the external serial input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous clear, active low |
| load_en | input | 1 | Parallel load request; takes priority over shifting |
| shift_en | input | 1 | Right-shift request |
| par_in | input | WIDTH | Word captured on load |
| ser_in | input | 1 | Bit entering the top position on shift |
| ser_out | output | 1 | Combinational copy of register bit 0 |
| par_out | output | WIDTH | Current register contents |

## Verification
A load, shift or hold presented before a rising edge shows on `par_out` right after that edge, so it is due one edge after the stimulus. The bench drives inputs just after a falling edge and compares outputs at the next falling edge, half a period after the edge that updated them. `ser_out` and the far end of a chained pair are due at the same time as `par_out`: the bench checks them against its model in that same comparison, which catches any extra flop in the serial path. The clear is checked a fraction of a nanosecond after `rst_n` falls in mid-cycle, before any clock edge could act.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } shreg_op_e;
endpackage

// File: rtl/shreg_op_decode.sv
module shreg_op_decode
  import shreg_pkg::*;
(
  input  logic      load_en,
  input  logic      shift_en,
  output shreg_op_e op
);
  // Load is tested first, so it wins over shift (R2)
  always_comb begin
    if (load_en)       op = OP_LOAD;
    else if (shift_en) op = OP_SHIFT;
    else               op = OP_HOLD;
  end
endmodule

// File: rtl/shreg_cell.sv
module shreg_cell
  import shreg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  shreg_op_e op,
  input  logic      par_bit,
  input  logic      chain_bit,
  output logic      q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      case (op)
        OP_LOAD:  q <= par_bit;
        OP_SHIFT: q <= chain_bit;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/shreg_chainable.sv
module shreg_chainable
  import shreg_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [WIDTH-1:0] par_out
);
  localparam int MSB = WIDTH - 1;

  shreg_op_e        op;
  logic [WIDTH-1:0] bits_q;
  logic [WIDTH-1:0] chain_in;

  shreg_op_decode u_decode (
    .load_en  (load_en),
    .shift_en (shift_en),
    .op       (op)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == MSB) begin : g_top
      assign chain_in[i] = ser_in;
    end else begin : g_inner
      assign chain_in[i] = bits_q[i+1];
    end

    shreg_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .par_bit   (par_in[i]),
      .chain_bit (chain_in[i]),
      .q         (bits_q[i])
    );
  end

  assign par_out = bits_q;
  assign ser_out = bits_q[0];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (par_out == '0 && ser_out == 1'b0));  // R1

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> par_out == $past(par_in));  // R2

  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && shift_en) |=> par_out == {$past(ser_in), $past(par_out[MSB:1])});  // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !shift_en) |=> $stable(par_out));  // R4

  AST_TAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && shift_en) |=> ser_out == $past(par_out[1 % WIDTH]) || WIDTH == 1);  // R5
endmodule

// File: tb/test_shreg_chainable.sv
module test_shreg_chainable;
  localparam int W = 5;

  logic         clk;
  logic         rst_n;
  logic         load_en, shift_en, ser_in;
  logic [W-1:0] par_in;
  logic         ser_out;
  logic [W-1:0] par_out;

  logic         c_load, c_shift, c_ser;
  logic [W-1:0] c_par_hi, c_par_lo;
  logic         mid, c_ser_out, hi_ser_unused;
  logic [W-1:0] hi_out, lo_out;

  int  n_checks = 0;
  int  n_fail   = 0;
  int  cycles   = 0;
  bit  run_chk  = 0;
  string cur_tag = "R1";

  logic [W-1:0]   model;
  logic [2*W-1:0] chain_model;

  shreg_chainable #(.WIDTH(W)) i_shreg_chainable (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .shift_en(shift_en),
    .par_in(par_in), .ser_in(ser_in), .ser_out(ser_out), .par_out(par_out));

  shreg_chainable #(.WIDTH(W)) i_shreg_chainable_hi (
    .clk(clk), .rst_n(rst_n), .load_en(c_load), .shift_en(c_shift),
    .par_in(c_par_hi), .ser_in(c_ser), .ser_out(mid), .par_out(hi_out));

  shreg_chainable #(.WIDTH(W)) i_shreg_chainable_lo (
    .clk(clk), .rst_n(rst_n), .load_en(c_load), .shift_en(c_shift),
    .par_in(c_par_lo), .ser_in(mid), .ser_out(c_ser_out), .par_out(lo_out));

  assign hi_ser_unused = mid;

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model       <= '0;
      chain_model <= '0;
    end else begin
      if (load_en)       model <= par_in;
      else if (shift_en) model <= {ser_in, model[W-1:1]};
      if (c_load)        chain_model <= {c_par_hi, c_par_lo};
      else if (c_shift)  chain_model <= {c_ser, chain_model[2*W-1:1]};
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (run_chk) begin
      chk(par_out === model, {cur_tag, " R6 par_out"}, 32'(par_out), 32'(model));
      chk(ser_out === model[0], "R5 ser_out tap", 32'(ser_out), 32'(model[0]));
      chk({hi_out, lo_out} === chain_model, "R7 chained word",
          32'({hi_out, lo_out}), 32'(chain_model));
      chk(c_ser_out === chain_model[0], "R7 chained tap",
          32'(c_ser_out), 32'(chain_model[0]));
    end
  end

  task automatic step(input logic l, input logic s, input logic [W-1:0] p,
                      input logic si, input string tag);
    @(negedge clk);
    #1;
    load_en = l; shift_en = s; par_in = p; ser_in = si; cur_tag = tag;
  endtask

  task automatic cstep(input logic l, input logic s, input logic [W-1:0] ph,
                       input logic [W-1:0] pl, input logic si);
    @(negedge clk);
    #1;
    c_load = l; c_shift = s; c_par_hi = ph; c_par_lo = pl; c_ser = si;
  endtask

  initial begin
    rst_n = 1'b1;
    load_en = 0; shift_en = 0; par_in = '0; ser_in = 0;
    c_load = 0; c_shift = 0; c_par_hi = '0; c_par_lo = '0; c_ser = 0;
    #1 rst_n = 1'b0;
    #0.5;
    chk(par_out === '0, "R1 reset value", 32'(par_out), 0);
    chk(ser_out === 1'b0, "R1 reset tap", 32'(ser_out), 0);
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    run_chk = 1;

    step(1, 0, 5'b10110, 0, "R2 load");
    step(0, 1, 5'b00000, 1, "R3 shift one");
    step(0, 1, 5'b00000, 0, "R3 shift zero");
    step(0, 0, 5'b11111, 1, "R4 hold");
    step(0, 0, 5'b00000, 0, "R4 hold");
    step(1, 1, 5'b01001, 1, "R2 load with shift");
    step(1, 1, 5'b11100, 0, "R2 load with shift");
    for (int k = 0; k < 7; k++) step(0, 1, 5'b10101, k[0], "R3 shift run");
    step(1, 0, 5'b00001, 1, "R2 load");
    step(0, 1, 5'b00000, 0, "R3 shift out");
    step(0, 0, 5'b00000, 0, "R4 hold");

    cstep(1, 0, 5'b11001, 5'b00111, 0);
    for (int k = 0; k < 12; k++) cstep(0, 1, 5'b00000, 5'b00000, (k % 3) == 0);
    cstep(1, 1, 5'b01010, 5'b10101, 1);
    cstep(0, 0, 5'b00000, 5'b00000, 1);
    cstep(0, 1, 5'b00000, 5'b00000, 1);
    cstep(0, 0, 5'b00000, 5'b00000, 0);

    // Mid-cycle asynchronous clear
    step(1, 0, 5'b11111, 1, "R2 load");
    @(posedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk(par_out === '0, "R1 async clear", 32'(par_out), 0);
    chk(ser_out === 1'b0, "R1 async clear tap", 32'(ser_out), 0);
    chk({hi_out, lo_out} === '0, "R1 async clear chain", 32'({hi_out, lo_out}), 0);
    step(0, 1, 5'b00000, 1, "R1 held in reset");
    @(negedge clk);
    #1 rst_n = 1'b1;
    step(0, 1, 5'b00000, 1, "R3 shift after reset");
    step(0, 0, 5'b00000, 0, "R4 hold");
    @(negedge clk);
    #1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule